// File: doc/BRIEF.md
# Programmable Quadrature Sample Oscillator

This block generates sampled sine and cosine waveforms from one shared phase position. A full turn of the circle is split into `N` equal slots. Each time the sample enable is high, the block presents the amplitudes of the current slot and then moves the slot forward by a programmable whole number of slots, `k`, wrapping modulo `N`. The output frequency is therefore `k·fS/N`, where `fS` is the rate of enabled samples. `N` can be any integer of 2 or more, and it does not have to be a power of two.

Both amplitudes come from tables that are built at elaboration time. The tables hold signed two's-complement codes that are symmetric about zero. An output sample is held in registers and announced by a one-cycle valid strobe. The stream has no back-pressure. A sample stays on the outputs until the next enabled sample replaces it, and a consumer that misses a strobe loses that sample. A warning pin goes high whenever the programmed step is above `N/2`. Such a step folds to the frequency of `N−k`.

Top module: `quad_osc`

## Requirements
- R1: A synchronous reset sets the phase slot to 0, clears the sine and cosine outputs to 0 and drops the valid strobe. The first enabled sample after reset presents slot 0.
- R2: On every clock edge with the enable high, the outputs load the values of the current slot. The slot then advances by `k` modulo `N`, for every value that the `k` input can carry.
- R3: While the enable is low, the phase slot and the sine and cosine outputs hold their values, and valid stays low.
- R4: For slot `i` and `A = 2^(W-1)-1`, the sine output equals round(A·sin(2πi/N)) and the cosine output equals round(A·cos(2πi/N)), both taken from the same slot. Rounding goes to the nearest integer, with halves rounded away from zero. The most negative code never appears on either output.
- R5: Valid is high for exactly the one cycle after each enabled edge. The phase output shows the slot that the presented sample belongs to.
- R6: The alias flag is combinational from `k` and is high exactly when `k > floor(N/2)`.
- R7: A change of `k` applies from the next enabled sample and does not move the phase, so the slot sequence continues from where it was.
- R8: With `k = N/2` (even `N`) and a start at slot 0, the cosine alternates +A and −A while the sine stays 0.
- R9: A step of `N−1` visits slots 0, N−1, N−2, …. The cosine sequence matches that of step 1 and the sine sequence is its negation.
- R10: When `N/k` is not an integer, successive output cycles begin on different slots. For example, N=10 and k=4 give slots 0,4,8,2,6,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample enable; one output sample per high cycle |
| step_k | input | $clog2(N) | Phase step in slots |
| sin_o | output | W | Signed sine sample |
| cos_o | output | W | Signed cosine sample |
| phase_o | output | $clog2(N) | Slot of the presented sample |
| valid_o | output | 1 | One-cycle strobe marking a new sample |
| alias_o | output | 1 | High when step_k exceeds N/2 |

## Verification
The bench builds two copies side by side, both with W=12. One uses N=16, a power of two, where steps of 8 and 15 reach the two-samples-per-cycle case and the mirror-image case. The other uses N=10, where a step of 4 makes cycles start on moving slots. Its 4-bit step input can carry values of N and above, so the double wrap of the modulo reduction is exercised.

// File: rtl/qosc_pkg.sv
package qosc_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Amplitude code for slot idx of n, signed, full scale 2^(w-1)-1.
  function automatic int wave_code(input int idx, input int n, input int w, input bit use_cos);
    real ang;
    real amp;
    real v;
    ang = TWO_PI * real'(idx) / real'(n);
    amp = real'((1 << (w - 1)) - 1);
    v   = use_cos ? amp * $cos(ang) : amp * $sin(ang);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else          return -$rtoi(-v + 0.5);
  endfunction

endpackage

// File: rtl/qosc_phase.sv
module qosc_phase #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [IW-1:0] step,
  output logic [IW-1:0] idx
);
  localparam int SW = IW + 2;
  localparam logic [SW-1:0] NW = SW'(N);

  logic [SW-1:0] sum, once, twice;

  // idx < N and step < 2N, so sum < 3N; two conditional subtractions reduce it.
  always_comb begin
    sum   = SW'(idx) + SW'(step);
    once  = (sum  >= NW) ? sum  - NW : sum;
    twice = (once >= NW) ? once - NW : once;
  end

  always_ff @(posedge clk) begin
    if (rst)     idx <= '0;
    else if (en) idx <= twice[IW-1:0];
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    SW'(idx) < NW);  // R2
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(idx));  // R3
  AST_RESET_SLOT: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> idx == '0);  // R1

endmodule

// File: rtl/qosc_lut.sv
module qosc_lut #(
  parameter int N  = 16,
  parameter int W  = 12,
  parameter int IW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [IW-1:0]       idx,
  output logic signed [W-1:0] sin_q,
  output logic signed [W-1:0] cos_q,
  output logic [IW-1:0]       ph_q,
  output logic                vld_q
);
  import qosc_pkg::*;

  localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] sin_tab [N];
  logic signed [W-1:0] cos_tab [N];

  for (genvar i = 0; i < N; i++) begin : g_tab
    assign sin_tab[i] = W'(wave_code(i, N, W, 1'b0));
    assign cos_tab[i] = W'(wave_code(i, N, W, 1'b1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sin_q <= '0;
      cos_q <= '0;
      ph_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= en;
      if (en) begin
        sin_q <= sin_tab[idx];
        cos_q <= cos_tab[idx];
        ph_q  <= idx;
      end
    end
  end

  AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (rst)
    sin_q != MOST_NEG && cos_q != MOST_NEG);  // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(sin_q) && $stable(cos_q) && $stable(ph_q));  // R3

endmodule

// File: rtl/quad_osc.sv
module quad_osc #(
  parameter int N  = 16,
  parameter int W  = 12,
  parameter int IW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_en,
  input  logic [IW-1:0]       step_k,
  output logic signed [W-1:0] sin_o,
  output logic signed [W-1:0] cos_o,
  output logic [IW-1:0]       phase_o,
  output logic                valid_o,
  output logic                alias_o
);
  localparam int HALF = N / 2;
  localparam logic signed [W-1:0] FULL = W'((1 << (W - 1)) - 1);

  logic [IW-1:0] slot;

  qosc_phase #(.N(N), .IW(IW)) u_phase (
    .clk (clk),
    .rst (rst),
    .en  (smp_en),
    .step(step_k),
    .idx (slot)
  );

  qosc_lut #(.N(N), .W(W), .IW(IW)) u_lut (
    .clk  (clk),
    .rst  (rst),
    .en   (smp_en),
    .idx  (slot),
    .sin_q(sin_o),
    .cos_q(cos_o),
    .ph_q (phase_o),
    .vld_q(valid_o)
  );

  assign alias_o = (32'(step_k) > HALF);

  AST_SLOT0_AMPL: assert property (@(posedge clk) disable iff (rst)
    valid_o && phase_o == '0 |-> cos_o == FULL && sin_o == '0);  // R4
  AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(smp_en) && $past(slot) == phase_o);  // R5

endmodule

// File: tb/tb_quad_osc.sv
`timescale 1ns/1ps
module tb_quad_osc;
  localparam int NA = 16;
  localparam int NB = 10;
  localparam int W  = 12;
  localparam int IA = $clog2(NA);
  localparam int IB = $clog2(NB);
  localparam real TP = 6.283185307179586;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [IA-1:0] k_a = '0;
  logic [IB-1:0] k_b = '0;
  logic signed [W-1:0] sin_a, cos_a, sin_b, cos_b;
  logic [IA-1:0] ph_a;
  logic [IB-1:0] ph_b;
  logic va, vb, al_a, al_b;

  always #10 clk = ~clk;

  quad_osc #(.N(NA), .W(W)) dut (
    .clk(clk), .rst(rst), .smp_en(en), .step_k(k_a),
    .sin_o(sin_a), .cos_o(cos_a), .phase_o(ph_a), .valid_o(va), .alias_o(al_a));

  quad_osc #(.N(NB), .W(W)) dut_b (
    .clk(clk), .rst(rst), .smp_en(en), .step_k(k_b),
    .sin_o(sin_b), .cos_o(cos_b), .phase_o(ph_b), .valid_o(vb), .alias_o(al_b));

  typedef struct {
    int    ph;
    int    s;
    int    c;
    string tag;
  } exp_t;

  exp_t qa[$];
  exp_t qb[$];
  int pa = 0, pb = 0;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  function automatic int amp(input int i, input int n, input bit use_cos);
    real v;
    v = real'((1 << (W - 1)) - 1) * (use_cos ? $cos(TP * i / n) : $sin(TP * i / n));
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // driver: one enabled sample, pushes expected results for both copies
  task automatic drive(input int ka, input int kb, input string tag);
    exp_t ea, eb;
    @(negedge clk);
    en = 1'b1; k_a = IA'(ka); k_b = IB'(kb);
    @(posedge clk);
    #1;
    ea.ph = pa; ea.s = amp(pa, NA, 1'b0); ea.c = amp(pa, NA, 1'b1); ea.tag = tag;
    eb.ph = pb; eb.s = amp(pb, NB, 1'b0); eb.c = amp(pb, NB, 1'b1); eb.tag = tag;
    qa.push_back(ea);
    qb.push_back(eb);
    pa = (pa + ka) % NA;
    pb = (pb + kb) % NB;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    en = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    pa = 0; pb = 0;
  endtask

  // monitor: pops and compares on every valid strobe
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (va) begin
        if (qa.size() == 0) chk(1'b0, "R5 unexpected valid (N=16)", 1, 0);
        else begin
          exp_t e;
          e = qa.pop_front();
          chk(32'(ph_a) == e.ph, {e.tag, " phase N=16"}, int'(ph_a), e.ph);
          chk(int'(sin_a) == e.s, {e.tag, " sine N=16"}, int'(sin_a), e.s);
          chk(int'(cos_a) == e.c, {e.tag, " cosine N=16"}, int'(cos_a), e.c);
        end
      end
      if (vb) begin
        if (qb.size() == 0) chk(1'b0, "R5 unexpected valid (N=10)", 1, 0);
        else begin
          exp_t e;
          e = qb.pop_front();
          chk(32'(ph_b) == e.ph, {e.tag, " phase N=10"}, int'(ph_b), e.ph);
          chk(int'(sin_b) == e.s, {e.tag, " sine N=10"}, int'(sin_b), e.s);
          chk(int'(cos_b) == e.c, {e.tag, " cosine N=10"}, int'(cos_b), e.c);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int held_ph, held_s;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(ph_a == '0 && ph_b == '0, "R1 phase after reset", int'(ph_a), 0);
    chk(sin_a == '0 && cos_a == '0, "R1 outputs after reset", int'(cos_a), 0);
    chk(!va && !vb, "R1 valid after reset", int'(va), 0);

    // R1/R4/R2: first sample is slot 0, then step 1 (N=16) and step 3 (N=10)
    drive(1, 3, "R1");
    for (int i = 0; i < 20; i++) drive(1, 3, "R2");

    // R3: enable low holds everything
    idle(4);
    @(negedge clk);
    held_ph = int'(ph_a); held_s = int'(sin_a);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!va && !vb, "R3 valid low while idle", int'(va), 0);
    chk(int'(ph_a) == held_ph, "R3 phase held", int'(ph_a), held_ph);
    chk(int'(sin_a) == held_s, "R3 sine held", int'(sin_a), held_s);
    // R3: phase resumes exactly where it stopped
    for (int i = 0; i < 3; i++) drive(1, 3, "R3");

    // R7: step changes keep phase continuity
    for (int i = 0; i < 5; i++) drive(3, 7, "R7");
    for (int i = 0; i < 5; i++) drive(5, 2, "R7");
    idle(3);

    // R8: half-rate step from slot 0 (N=16: k=8; N=10: k=5)
    do_reset();
    for (int i = 0; i < 6; i++) drive(8, 5, "R8");
    idle(3);

    // R9: step N-1 mirrors step 1; N=10 copy uses k=14 to exercise double wrap (R2)
    do_reset();
    for (int i = 0; i < 17; i++) drive(15, 14, "R9");
    idle(3);

    // R10: N=10, k=4 cycles begin on moving slots
    do_reset();
    for (int i = 0; i < 12; i++) drive(2, 4, "R10");
    idle(3);
    chk(qa.size() == 0 && qb.size() == 0, "R5 all samples delivered", qa.size() + qb.size(), 0);

    // R6: alias flag against floor(N/2)
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      k_a = IA'(k); k_b = IB'(k);
      #1;
      chk(al_a == (k > NA / 2), "R6 alias N=16", int'(al_a), int'(k > NA / 2));
      chk(al_b == (k > NB / 2), "R6 alias N=10", int'(al_b), int'(k > NB / 2));
    end
    finish_run();
  end

endmodule